// File: doc/BRIEF.md
# Dual-Representation Complement Adder/Subtractor

This block is a purely combinational signed adder/subtractor for two N-bit operands. N is 8 by default. A mode input selects how the operands are interpreted: one's-complement or two's-complement. An op input selects addition or subtraction. Both representations share one N-bit adder.

Subtraction negates the subtrahend in the active representation and then adds it to the minuend:

- In two's-complement mode the negation is an inversion, and the extra one enters as the adder's carry-in. The carry out of the top bit is dropped.
- In one's-complement mode the negation is a plain inversion. The carry out of the top bit is folded back into the low end of the sum (end-around carry).

The outputs are:

- the N-bit result;
- the raw carry out of the first-pass addition;
- an overflow flag, judged on the effective operands;
- a flag that reports a one's-complement result of all ones, the negative encoding of zero.

A normalize input rewrites that negative zero to all zeros. A parameter selects either a bit-serial carry chain or a lookahead carry network inside the adder.

Top module: `cadd_dual_top`

## Requirements
- R1: With two's-complement mode (ones_mode_i=0) and add (sub_i=0), sum_o equals (a_i + b_i) mod 2^N.
- R2: With two's-complement mode and subtract (sub_i=1), sum_o equals (a_i - b_i) mod 2^N. For N=8, 7 minus 12 gives 8'hFB.
- R3: With one's-complement mode (ones_mode_i=1) and add, let t = a_i + b_i, taken to N+1 bits. sum_o is then t mod 2^N, plus one when bit N of t is set (end-around carry).
- R4: With one's-complement mode and subtract, b_i is bitwise inverted and then added as in R3. For N=8, 35 minus 22 gives 8'h0D, and 22 minus 35 gives 8'hF2 with carry_o=0.
- R5: carry_o is bit N of the first-pass sum a_i + eb + c0 in both modes. Here eb is b_i when adding and ~b_i when subtracting. c0 is 1 only for a two's-complement subtraction.
- R6: ovf_o is 1 exactly when the signed result does not fit in the active representation. For two's complement the range is -2^(N-1)..2^(N-1)-1, and for one's complement it is -(2^(N-1)-1)..2^(N-1)-1. This is equivalent to the rule that the effective operands share a sign bit and the pre-normalization result has the other sign. Operands of opposite effective sign never overflow. In two's complement, 0 minus the most negative value overflows.
- R7: In one's-complement mode without overflow, sum_o decodes to the true sum or difference. Both all-zeros and all-ones decode to zero.
- R8: negzero_o is 1 exactly when ones_mode_i=1 and the pre-normalization result is all ones. It is always 0 in two's-complement mode.
- R9: With norm_i=1, a result flagged by negzero_o is driven onto sum_o as all zeros. In every other case norm_i has no effect on sum_o.
- R10: The ripple (ADDER_KIND=0) and lookahead (ADDER_KIND=1) variants give identical outputs for identical inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | N | Minuend or first addend |
| b_i | input | N | Subtrahend or second addend |
| ones_mode_i | input | 1 | 1 = one's complement, 0 = two's complement |
| sub_i | input | 1 | 1 = subtract, 0 = add |
| norm_i | input | 1 | Rewrite a negative-zero result to all zeros |
| sum_o | output | N | Result |
| carry_o | output | 1 | Carry out of the first-pass addition |
| ovf_o | output | 1 | Signed overflow |
| negzero_o | output | 1 | One's-complement result was all ones |

## Verification
No register lies anywhere between the inputs and the outputs, so every result is due in the same cycle its stimulus is applied. The bench changes the inputs just after a rising edge. It samples all four outputs at the following falling edge, half a period later, once the logic has settled. The bench never compares values across cycles. The same timing applies to the exhaustive 4-bit sweep, the random 8-bit sweep and the comparison between the two adder variants.

// File: rtl/cadd_pkg.sv
`timescale 1ns/1ps
package cadd_pkg;
   // operand interpretation selected by ones_mode_i
   typedef enum logic {
      REP_TWOS = 1'b0,
      REP_ONES = 1'b1
   } cadd_rep_e;

   // carry network variants of the core adder
   localparam int KIND_RIPPLE    = 0;
   localparam int KIND_LOOKAHEAD = 1;
   localparam int KIND_COUNT     = 2;
endpackage

// File: rtl/cadd_operand_prep.sv
`timescale 1ns/1ps
// Forms the effective second addend and the adder carry-in.
module cadd_operand_prep
   import cadd_pkg::*;
#(
   parameter int N = 8
) (
   input  logic [N-1:0] b_in,
   input  logic         sub_in,
   input  cadd_rep_e    rep_in,
   output logic [N-1:0] eff_b_out,
   output logic         cin_out
);
   if (N < 2) begin : g_bad_n
      $error("cadd_operand_prep: N must be at least 2");
   end

   // inversion mask: all ones while subtracting
   logic [N-1:0] inv_mask;
   assign inv_mask  = {N{sub_in}};
   assign eff_b_out = b_in ^ inv_mask;
   // the +1 of two's-complement negation rides on the carry-in
   assign cin_out   = sub_in & (rep_in == REP_TWOS);
endmodule

// File: rtl/cadd_core_adder.sv
`timescale 1ns/1ps
// N-bit adder with carry-in; the carry network is chosen by ADDER_KIND.
module cadd_core_adder
   import cadd_pkg::*;
#(
   parameter int N          = 8,
   parameter int ADDER_KIND = KIND_RIPPLE
) (
   input  logic [N-1:0] x_in,
   input  logic [N-1:0] y_in,
   input  logic         cin_in,
   output logic [N-1:0] sum_out,
   output logic         cout_out
);
   localparam int CW = N + 1;

   if (N < 2) begin : g_bad_n
      $error("cadd_core_adder: N must be at least 2");
   end
   if (ADDER_KIND < 0 || ADDER_KIND >= KIND_COUNT) begin : g_bad_kind
      $error("cadd_core_adder: unknown ADDER_KIND");
   end

   logic [N-1:0]  gen_w;
   logic [N-1:0]  prop_w;
   logic [CW-1:0] carry_w;

   assign gen_w  = x_in & y_in;
   assign prop_w = x_in ^ y_in;

   if (ADDER_KIND == KIND_LOOKAHEAD) begin : g_lookahead
      // every carry is a flat sum of generate terms qualified by propagates
      always_comb begin
         logic term_or;
         logic term;
         carry_w    = '0;
         carry_w[0] = cin_in;
         for (int i = 0; i < N; i++) begin
            term = cin_in;
            for (int j = 0; j <= i; j++) begin
               term = term & prop_w[j];
            end
            term_or = term;
            for (int j = 0; j <= i; j++) begin
               term = gen_w[j];
               for (int k = j + 1; k <= i; k++) begin
                  term = term & prop_w[k];
               end
               term_or = term_or | term;
            end
            carry_w[i+1] = term_or;
         end
      end
   end else begin : g_ripple
      // carry passes one bit position at a time
      always_comb begin
         carry_w    = '0;
         carry_w[0] = cin_in;
         for (int i = 0; i < N; i++) begin
            carry_w[i+1] = gen_w[i] | (prop_w[i] & carry_w[i]);
         end
      end
   end

   assign sum_out  = prop_w ^ carry_w[N-1:0];
   assign cout_out = carry_w[N];
endmodule

// File: rtl/cadd_eac_stage.sv
`timescale 1ns/1ps
// Applies the end-around carry in one's-complement mode, flags negative
// zero, and optionally rewrites it to positive zero.
module cadd_eac_stage
   import cadd_pkg::*;
#(
   parameter int N = 8
) (
   input  logic [N-1:0] first_sum_in,
   input  logic         first_cout_in,
   input  cadd_rep_e    rep_in,
   input  logic         norm_in,
   output logic [N-1:0] pre_sum_out,
   output logic [N-1:0] final_sum_out,
   output logic         negzero_out
);
   if (N < 2) begin : g_bad_n
      $error("cadd_eac_stage: N must be at least 2");
   end

   logic         wrap_w;
   logic [N-1:0] inc_sum_w;
   logic [N:0]   inc_carry_w;

   assign wrap_w = first_cout_in & (rep_in == REP_ONES);

   // half-adder incrementer; a first-pass carry implies the first sum is at
   // most 2^N-2, so the top carry of this pass is always zero
   assign inc_carry_w[0] = wrap_w;
   for (genvar i = 0; i < N; i++) begin : g_inc
      assign inc_sum_w[i]     = first_sum_in[i] ^ inc_carry_w[i];
      assign inc_carry_w[i+1] = first_sum_in[i] & inc_carry_w[i];
   end

   assign pre_sum_out   = inc_sum_w;
   assign negzero_out   = (rep_in == REP_ONES) & (&inc_sum_w);
   assign final_sum_out = (norm_in & negzero_out) ? '0 : inc_sum_w;
endmodule

// File: rtl/cadd_dual_top.sv
`timescale 1ns/1ps
module cadd_dual_top
   import cadd_pkg::*;
#(
   parameter int N          = 8,
   parameter int ADDER_KIND = KIND_RIPPLE
) (
   input  logic [N-1:0] a_i,
   input  logic [N-1:0] b_i,
   input  logic         ones_mode_i,
   input  logic         sub_i,
   input  logic         norm_i,
   output logic [N-1:0] sum_o,
   output logic         carry_o,
   output logic         ovf_o,
   output logic         negzero_o
);
   localparam int MSB = N - 1;

   if (N < 2) begin : g_bad_n
      $error("cadd_dual_top: N must be at least 2");
   end

   cadd_rep_e    rep_w;
   logic [N-1:0] eff_b_w;
   logic         cin_w;
   logic [N-1:0] first_sum_w;
   logic         first_cout_w;
   logic [N-1:0] pre_sum_w;

   assign rep_w = ones_mode_i ? REP_ONES : REP_TWOS;

   cadd_operand_prep #(.N(N)) i_prep (
      .b_in      (b_i),
      .sub_in    (sub_i),
      .rep_in    (rep_w),
      .eff_b_out (eff_b_w),
      .cin_out   (cin_w)
   );

   cadd_core_adder #(.N(N), .ADDER_KIND(ADDER_KIND)) i_adder (
      .x_in     (a_i),
      .y_in     (eff_b_w),
      .cin_in   (cin_w),
      .sum_out  (first_sum_w),
      .cout_out (first_cout_w)
   );

   cadd_eac_stage #(.N(N)) i_eac (
      .first_sum_in  (first_sum_w),
      .first_cout_in (first_cout_w),
      .rep_in        (rep_w),
      .norm_in       (norm_i),
      .pre_sum_out   (pre_sum_w),
      .final_sum_out (sum_o),
      .negzero_out   (negzero_o)
   );

   assign carry_o = first_cout_w;
   // same-sign rule on the effective operands, judged before normalization
   assign ovf_o   = (a_i[MSB] == eff_b_w[MSB]) & (pre_sum_w[MSB] != a_i[MSB]);
endmodule

// File: rtl/cadd_dual_chk.sv
`timescale 1ns/1ps
module cadd_dual_chk #(
   parameter int N = 8
) (
   input logic [N-1:0] a_i,
   input logic [N-1:0] b_i,
   input logic         ones_mode_i,
   input logic         sub_i,
   input logic         norm_i,
   input logic [N-1:0] sum_o,
   input logic         carry_o,
   input logic         ovf_o,
   input logic         negzero_o,
   input logic [N-1:0] eff_b_w
);
   localparam int MSB = N - 1;

   logic [N-1:0] plain_add_w;
   logic [N-1:0] plain_sub_w;
   assign plain_add_w = a_i + b_i;
   assign plain_sub_w = a_i - b_i;

   always_comb begin
      // R1
      twos_add_chk: assert (ones_mode_i || sub_i || sum_o == plain_add_w)
         else $error("two's-complement add result mismatch");
      // R2
      twos_sub_chk: assert (ones_mode_i || !sub_i || sum_o == plain_sub_w)
         else $error("two's-complement subtract result mismatch");
      // R6
      opp_sign_chk: assert ((a_i[MSB] == eff_b_w[MSB]) || !ovf_o)
         else $error("overflow raised for operands of opposite sign");
      // R8
      negzero_twos_chk: assert (ones_mode_i || !negzero_o)
         else $error("negative zero flagged in two's-complement mode");
      // R9
      norm_zero_chk: assert (!(norm_i && negzero_o) || sum_o == '0)
         else $error("normalized negative zero not cleared");
   end
endmodule

bind cadd_dual_top cadd_dual_chk #(.N(N)) i_cadd_dual_chk (
   .a_i         (a_i),
   .b_i         (b_i),
   .ones_mode_i (ones_mode_i),
   .sub_i       (sub_i),
   .norm_i      (norm_i),
   .sum_o       (sum_o),
   .carry_o     (carry_o),
   .ovf_o       (ovf_o),
   .negzero_o   (negzero_o),
   .eff_b_w     (eff_b_w)
);

// File: tb/test_cadd_dual_top.sv
`timescale 1ns/1ps
module test_cadd_dual_top;
   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic       rst;
   logic [7:0] a8, b8;
   logic [3:0] a4, b4;
   logic       ones, sub, norm;
   logic [7:0] s8, sl;
   logic [3:0] s4;
   logic       c8, o8, z8, cl, ol, zl, c4, o4, z4;
   int         total = 0;
   int         bad = 0;
   bit         done = 1'b0;

   cadd_dual_top #(.N(8), .ADDER_KIND(0)) i_cadd_dual_top (
      .a_i(a8), .b_i(b8), .ones_mode_i(ones), .sub_i(sub), .norm_i(norm),
      .sum_o(s8), .carry_o(c8), .ovf_o(o8), .negzero_o(z8));

   cadd_dual_top #(.N(8), .ADDER_KIND(1)) i_cadd_dual_top_la8 (
      .a_i(a8), .b_i(b8), .ones_mode_i(ones), .sub_i(sub), .norm_i(norm),
      .sum_o(sl), .carry_o(cl), .ovf_o(ol), .negzero_o(zl));

   cadd_dual_top #(.N(4), .ADDER_KIND(1)) i_cadd_dual_top_w4 (
      .a_i(a4), .b_i(b4), .ones_mode_i(ones), .sub_i(sub), .norm_i(norm),
      .sum_o(s4), .carry_o(c4), .ovf_o(o4), .negzero_o(z4));

   task automatic chk(input string tag, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d (a8=%0d b8=%0d a4=%0d b4=%0d ones=%0b sub=%0b norm=%0b)",
                  tag, what, act, exp, a8, b8, a4, b4, ones, sub, norm);
      end
   endtask

   function automatic int decode(input int w, input bit om, input int x);
      int m = (1 << w) - 1;
      int h = 1 << (w - 1);
      if ((x & h) == 0) return x;
      return om ? -((~x) & m) : x - (1 << w);
   endfunction

   // compare one instance's outputs with the arithmetic model
   task automatic check_one(input int w, input int a, input int b,
                            input int res, input bit cy, input bit ov, input bit nz);
      int m = (1 << w) - 1;
      int h = 1 << (w - 1);
      int eb = sub ? ((~b) & m) : b;
      int t = a + eb + ((sub && !ones) ? 1 : 0);
      int e_cy = (t >> w) & 1;
      int pre = t & m;
      int truev, lo, e_ov, e_nz, e_res;
      string tag;
      if (ones) pre = pre + e_cy;
      truev = sub ? decode(w, ones, a) - decode(w, ones, b)
                  : decode(w, ones, a) + decode(w, ones, b);
      lo    = ones ? -(h - 1) : -h;
      e_ov  = (truev < lo || truev > h - 1) ? 1 : 0;
      e_nz  = (ones && pre == m) ? 1 : 0;
      e_res = (norm && e_nz) ? 0 : pre;
      if (norm)      tag = "R9";
      else if (ones) tag = sub ? "R4" : "R3";
      else           tag = sub ? "R2" : "R1";
      chk(tag, "sum", res, e_res);
      chk("R5", "carry", int'(cy), e_cy);
      chk("R6", "ovf", int'(ov), e_ov);
      chk("R8", "negzero", int'(nz), e_nz);
      if (!ones)
         chk(sub ? "R2" : "R1", "modular", res, (sub ? a - b : a + b) & m);
      else if (e_ov == 0)
         chk("R7", "value", decode(w, 1'b1, res), truev);
   endtask

   task automatic check_all();
      check_one(8, int'(a8), int'(b8), int'(s8), c8, o8, z8);
      check_one(4, int'(a4), int'(b4), int'(s4), c4, o4, z4);
      // R10 ripple and lookahead agree
      chk("R10", "variant", {sl, cl, ol, zl}, {s8, c8, o8, z8});
   endtask

   task automatic apply(input logic [7:0] na8, input logic [7:0] nb8,
                        input logic [3:0] na4, input logic [3:0] nb4,
                        input bit no, input bit ns, input bit nn);
      @(posedge clk);
      a8 = na8; b8 = nb8; a4 = na4; b4 = nb4;
      ones = no; sub = ns; norm = nn;
      @(negedge clk);
      check_all();
   endtask

   function automatic logic [7:0] pick8();
      logic [7:0] edges [4] = '{8'h00, 8'h7F, 8'h80, 8'hFF};
      if ($urandom_range(3) == 0) return edges[$urandom_range(3)];
      return 8'($urandom);
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      rst = 1'b1;
      a8 = '0; b8 = '0; a4 = '0; b4 = '0; ones = 0; sub = 0; norm = 0;
      repeat (3) @(posedge clk);
      rst = 1'b0;
      @(negedge clk);
      // reset state: zero inputs give zero outputs (R1)
      chk("R1", "reset sum", int'(s8), 0);
      chk("R1", "reset flags", int'({c8, o8, z8}), 0);

      // R4 directed one's-complement examples
      apply(8'd35, 8'd22, 4'd0, 4'd0, 1, 1, 0);
      chk("R4", "35-22", int'(s8), 8'h0D);
      apply(8'd22, 8'd35, 4'd0, 4'd0, 1, 1, 0);
      chk("R4", "22-35", int'(s8), 8'hF2);
      chk("R4", "22-35 carry", int'(c8), 0);
      // R2 directed two's-complement example
      apply(8'd7, 8'd12, 4'd0, 4'd0, 0, 1, 0);
      chk("R2", "7-12", int'(s8), 8'hFB);
      // R6 negating the most negative value
      apply(8'h00, 8'h80, 4'h0, 4'h8, 0, 1, 0);
      chk("R6", "0-min ovf8", int'(o8), 1);
      chk("R6", "0-min ovf4", int'(o4), 1);
      // R8 and R9: 5 + (-5) in one's complement gives negative zero
      apply(8'h05, 8'hFA, 4'h5, 4'hA, 1, 0, 0);
      chk("R8", "neg zero", int'(z8), 1);
      chk("R8", "neg zero sum", int'(s8), 8'hFF);
      apply(8'h05, 8'hFA, 4'h5, 4'hA, 1, 0, 1);
      chk("R9", "normalized", int'(s8), 0);

      // exhaustive 4-bit sweep with random 8-bit operands alongside
      for (int mo = 0; mo < 2; mo++)
         for (int so = 0; so < 2; so++)
            for (int no = 0; no < 2; no++)
               for (int av = 0; av < 16; av++)
                  for (int bv = 0; bv < 16; bv++)
                     apply(pick8(), pick8(), 4'(av), 4'(bv), mo[0], so[0], no[0]);

      // random 8-bit sweep
      for (int k = 0; k < 3000; k++)
         apply(pick8(), pick8(), 4'($urandom), 4'($urandom),
               1'($urandom), 1'($urandom), 1'($urandom));

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule